// File: doc/BRIEF.md
# Dual-Mode Infrared Line Modulator

This block sits between a UART and an infrared transceiver. On the transmit side it takes the UART's serial output and turns each zero bit into light on the line. Light only means a zero; a one bit, the idle line and the stop bits send nothing. Two encodings are available. In pulse mode a zero bit becomes one short pulse, 3/16 of a bit long, placed at the start of the bit. This mode is meant for rates up to 115.2 kbps. In carrier mode a zero bit becomes a 50% duty square wave that lasts the whole bit. Its frequency comes from dividing the system clock, and the default gives 500 kHz at a 50 MHz clock. This mode is meant for rates up to 19.2 kbaud.

The receive side reverses the encoding. In pulse mode each detected pulse holds the recovered serial line low for one full bit, counted as 16 ticks of the 16x baud enable. In carrier mode the line is held low while carrier edges keep arriving, and it is released once two carrier periods pass with no edge. A route select picks which pins the modulated signals use: the shared UART transmit/receive pins or the dedicated infrared transmit/receive pins.

Top module: `ir_modem`

## Requirements
- R1: While reset is asserted and right after it is released, both transmit pins are low (no light).
- R2: In pulse mode (mode_ask_i=0), a zero on uart_txd_i produces a high pulse on the routed transmit pin. The pulse is exactly 3 tick16_i periods wide. It goes high after the first tick of the bit, which is the first tick at which the sampled uart_txd_i differs from the value at the previous tick.
- R3: In pulse mode, a one bit produces no pulse during its 16 ticks.
- R4: In pulse mode, consecutive zero bits produce one pulse per bit, 16 ticks apart, with no new edge on uart_txd_i.
- R5: In carrier mode (mode_ask_i=1), a zero on uart_txd_i drives the routed transmit pin with a square wave of HALF_DIV clocks high and HALF_DIV clocks low.
- R6: In carrier mode, a one on uart_txd_i keeps the transmit pins low from the following clock onward.
- R7: With route_ir_i=1 the modulated signal goes to irtx_o and txd_pin_o stays low. With route_ir_i=0 it goes to txd_pin_o and irtx_o stays low.
- R8: The receive source is irrx_i when route_ir_i=1 and rxd_pin_i when route_ir_i=0. A pulse on the unselected pin leaves uart_rxd_o high.
- R9: In pulse mode, a rising edge on the selected receive pin drives uart_rxd_o low within 3 clocks. uart_rxd_o stays low until the 16th tick16_i after the edge and goes high at that tick.
- R10: In carrier mode, uart_rxd_o is low while edges arrive on the selected receive pin less than 4*HALF_DIV clocks apart. It returns high once no edge has been seen for 4*HALF_DIV clocks.
- R11: uart_rxd_o idles high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_ask_i | input | 1 | 0 = short-pulse encoding, 1 = carrier encoding |
| route_ir_i | input | 1 | 0 = shared UART pins, 1 = dedicated IR pins |
| tick16_i | input | 1 | Enable at 16 times the bit rate, one clock wide |
| uart_txd_i | input | 1 | Serial output of the UART transmitter |
| uart_rxd_o | output | 1 | Recovered serial line for the UART receiver |
| txd_pin_o | output | 1 | Shared UART transmit pin (active high light) |
| rxd_pin_i | input | 1 | Shared UART receive pin (active high light) |
| irtx_o | output | 1 | Dedicated IR transmit pin |
| irrx_i | input | 1 | Dedicated IR receive pin |

## Verification
A bit-phase counter that is out of step shows up at the transmit pin within one bit. The pulse lands on the wrong ticks or goes missing on the second of two zeros, and the bench compares the full tick-by-tick pattern of each bit on both pins. A wrong carrier divider shows up in the first high or low run after the first edge. A receive counter that is loaded wrong or released early appears at uart_rxd_o, which goes high one tick too soon or too late, or, in carrier mode, drops out during an edge gap shorter than the window. Routing errors put light on the unselected pin, or let a pulse on the wrong input through, within a few clocks.

// File: rtl/ir_modem_pkg.sv
package ir_modem_pkg;
  typedef enum logic {
    MOD_PULSE   = 1'b0,
    MOD_CARRIER = 1'b1
  } mod_e;
endpackage

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int HALF_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic carrier_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          car_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RELOAD;
      car_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q <= RELOAD;
      car_q <= ~car_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign carrier_o = car_q;
endmodule

// File: rtl/ir_tx_encoder.sv
module ir_tx_encoder
  import ir_modem_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic txd_i,
  input  logic carrier_i,
  input  mod_e mode_i,
  output logic line_o
);
  localparam int PW = $clog2(OVERSAMPLE);
  localparam logic [PW-1:0] LAST = PW'(OVERSAMPLE - 1);
  localparam logic [PW-1:0] PEND = PW'(PULSE_TICKS);

  logic          txd_q;
  logic [PW-1:0] phase_q;
  logic [PW-1:0] pos;
  logic          pulse_q;
  logic          ask_q;

  // a level change seen at a tick marks the first tick of a new bit
  always_comb begin
    pos = (txd_i != txd_q) ? '0 : phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q   <= 1'b1;
      phase_q <= '0;
      pulse_q <= 1'b0;
      ask_q   <= 1'b0;
    end else begin
      ask_q <= ~txd_i & carrier_i;
      if (tick_i) begin
        txd_q   <= txd_i;
        phase_q <= (pos == LAST) ? '0 : pos + 1'b1;
        pulse_q <= ~txd_i & (pos < PEND);
      end
    end
  end

  assign line_o = (mode_i == MOD_CARRIER) ? ask_q : pulse_q;
endmodule

// File: rtl/ir_rx_decoder.sv
module ir_rx_decoder
  import ir_modem_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int HALF_DIV   = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  mod_e mode_i,
  output logic rxd_o
);
  localparam int BW  = $clog2(OVERSAMPLE + 1);
  localparam int WIN = 4 * HALF_DIV;
  localparam int WW  = $clog2(WIN + 1);
  localparam logic [BW-1:0] BIT_LOAD = BW'(OVERSAMPLE);
  localparam logic [WW-1:0] WIN_LOAD = WW'(WIN);

  logic [2:0]    sync_q;
  logic          rise, any_edge;
  logic [BW-1:0] bit_q;
  logic [WW-1:0] win_q;

  assign rise     = sync_q[1] & ~sync_q[2];
  assign any_edge = sync_q[1] ^ sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      bit_q  <= '0;
      win_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], line_i};
      if (rise)                      bit_q <= BIT_LOAD;
      else if (tick_i && bit_q != '0) bit_q <= bit_q - 1'b1;
      if (any_edge)                  win_q <= WIN_LOAD;
      else if (win_q != '0)          win_q <= win_q - 1'b1;
    end
  end

  assign rxd_o = (mode_i == MOD_CARRIER) ? (win_q == '0) : (bit_q == '0);
endmodule

// File: rtl/ir_modem.sv
module ir_modem
  import ir_modem_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 3,
  parameter int HALF_DIV    = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_ask_i,
  input  logic route_ir_i,
  input  logic tick16_i,
  input  logic uart_txd_i,
  output logic uart_rxd_o,
  output logic txd_pin_o,
  input  logic rxd_pin_i,
  output logic irtx_o,
  input  logic irrx_i
);
  mod_e mode;
  logic carrier, tx_line, rx_line;

  assign mode = mod_e'(mode_ask_i);

  ir_carrier_gen #(.HALF_DIV(HALF_DIV)) i_car (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .carrier_o(carrier)
  );

  ir_tx_encoder #(.OVERSAMPLE(OVERSAMPLE), .PULSE_TICKS(PULSE_TICKS)) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick16_i),
    .txd_i    (uart_txd_i),
    .carrier_i(carrier),
    .mode_i   (mode),
    .line_o   (tx_line)
  );

  assign rx_line = route_ir_i ? irrx_i : rxd_pin_i;

  ir_rx_decoder #(.OVERSAMPLE(OVERSAMPLE), .HALF_DIV(HALF_DIV)) i_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick16_i),
    .line_i(rx_line),
    .mode_i(mode),
    .rxd_o (uart_rxd_o)
  );

  assign irtx_o    = route_ir_i  & tx_line;
  assign txd_pin_o = ~route_ir_i & tx_line;
endmodule

// File: rtl/ir_modem_chk.sv
module ir_modem_chk #(
  parameter int PULSE_TICKS = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_ask_i,
  input logic route_ir_i,
  input logic tick16_i,
  input logic uart_txd_i,
  input logic uart_rxd_o,
  input logic txd_pin_o,
  input logic irtx_o
);
  logic       light;
  logic [7:0] hi_ticks_q;

  assign light = irtx_o | txd_pin_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hi_ticks_q <= '0;
    else if (mode_ask_i || !light) hi_ticks_q <= '0;
    else if (tick16_i && hi_ticks_q != 8'hff) hi_ticks_q <= hi_ticks_q + 1'b1;
  end

  AST_RESET_DARK: assert property (@(posedge clk_i) !rst_ni |=> !light || rst_ni); // R1
  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_ask_i |-> hi_ticks_q <= 8'(PULSE_TICKS)); // R2
  AST_ONE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_ask_i && $past(uart_txd_i) |-> !light); // R6
  AST_IR_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_ir_i |-> !txd_pin_o); // R7
  AST_UART_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_ir_i |-> !irtx_o); // R7
  AST_RX_RELEASE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_ask_i && $past(!mode_ask_i) && $rose(uart_rxd_o) |-> $past(tick16_i)); // R9
endmodule

bind ir_modem ir_modem_chk #(.PULSE_TICKS(PULSE_TICKS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_ask_i(mode_ask_i),
  .route_ir_i(route_ir_i),
  .tick16_i  (tick16_i),
  .uart_txd_i(uart_txd_i),
  .uart_rxd_o(uart_rxd_o),
  .txd_pin_o (txd_pin_o),
  .irtx_o    (irtx_o)
);

// File: tb/test_ir_modem.sv
module test_ir_modem;
  localparam int HALF = 10;
  localparam int GAP  = 3;
  localparam int NVEC = 12;
  // {route_ir, bit}
  localparam logic [1:0] VEC [NVEC] = '{
    2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b11,
    2'b00, 2'b00, 2'b01, 2'b00, 2'b11, 2'b10
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_ask = 1'b0, route_ir = 1'b1, tick = 1'b0, txd = 1'b1;
  logic rxd_pin = 1'b0, irrx = 1'b0;
  logic uart_rxd, txd_pin, irtx;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ir_modem #(.HALF_DIV(HALF)) i_ir_modem (
    .clk_i(clk), .rst_ni(rst_ni), .mode_ask_i(mode_ask), .route_ir_i(route_ir),
    .tick16_i(tick), .uart_txd_i(txd), .uart_rxd_o(uart_rxd),
    .txd_pin_o(txd_pin), .rxd_pin_i(rxd_pin), .irtx_o(irtx), .irrx_i(irrx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick(output logic s_ir, output logic s_pin);
    @(negedge clk) tick = 1'b1;
    @(negedge clk);
    s_ir = irtx; s_pin = txd_pin;
    tick = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    logic a, b;
    for (int i = 0; i < n; i++) do_tick(a, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] m_ir, m_pin, e_sel;
    logic a, b;
    int n, tog;
    repeat (3) @(negedge clk);
    check(!irtx && !txd_pin, "R1 dark in reset", {irtx, txd_pin}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!irtx && !txd_pin, "R1 dark after reset", {irtx, txd_pin}, 0);
    check(uart_rxd, "R11 rx idle", uart_rxd, 1);

    // pulse mode tx: R2 R3 R4 R7
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      route_ir = VEC[v][1];
      txd      = VEC[v][0];
      m_ir = '0; m_pin = '0;
      for (int j = 0; j < 16; j++) begin
        do_tick(a, b);
        m_ir[j] = a; m_pin[j] = b;
      end
      e_sel = VEC[v][0] ? 16'h0000 : 16'h0007;
      check(m_ir  == (VEC[v][1] ? e_sel : 16'h0), "R2 R3 R4 R7 irtx pattern", m_ir,
            VEC[v][1] ? e_sel : 16'h0);
      check(m_pin == (VEC[v][1] ? 16'h0 : e_sel), "R2 R3 R4 R7 txd_pin pattern", m_pin,
            VEC[v][1] ? 16'h0 : e_sel);
    end

    // carrier tx: R5 R6
    mode_ask = 1'b1; route_ir = 1'b1; txd = 1'b0;
    n = 0;
    @(negedge clk);
    while (!(irtx == 1'b0) && n < 100) begin @(negedge clk); n++; end
    while (irtx == 1'b0 && n < 200) begin @(negedge clk); n++; end
    n = 0;
    while (irtx && n < 100) begin @(negedge clk); n++; end
    check(n == HALF, "R5 carrier high run", n, HALF);
    n = 0;
    while (!irtx && n < 100) begin @(negedge clk); n++; end
    check(n == HALF, "R5 carrier low run", n, HALF);
    txd = 1'b1;
    @(negedge clk);
    n = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); n += int'(irtx | txd_pin); end
    check(n == 0, "R6 one bit dark", n, 0);
    // carrier on shared pin: R7
    route_ir = 1'b0; txd = 1'b0;
    @(negedge clk);
    tog = 0; n = 0;
    for (int i = 0; i < 40; i++) begin
      a = txd_pin;
      @(negedge clk);
      tog += int'(a != txd_pin); n += int'(irtx);
    end
    check(tog >= 3 && n == 0, "R7 carrier on txd_pin only", tog, 4);
    txd = 1'b1;

    // pulse rx: R9 R8
    mode_ask = 1'b0; route_ir = 1'b1;
    repeat (4) @(negedge clk);
    irrx = 1'b1; repeat (2) @(negedge clk); irrx = 1'b0;
    repeat (4) @(negedge clk);
    check(!uart_rxd, "R9 rx low after pulse", uart_rxd, 0);
    ticks(15);
    check(!uart_rxd, "R9 rx low through 15 ticks", uart_rxd, 0);
    do_tick(a, b);
    check(uart_rxd, "R9 rx high at tick 16", uart_rxd, 1);
    rxd_pin = 1'b1; repeat (2) @(negedge clk); rxd_pin = 1'b0;
    repeat (6) @(negedge clk);
    check(uart_rxd, "R8 unselected pin ignored", uart_rxd, 1);
    route_ir = 1'b0;
    @(negedge clk);
    rxd_pin = 1'b1; repeat (2) @(negedge clk); rxd_pin = 1'b0;
    repeat (4) @(negedge clk);
    check(!uart_rxd, "R8 shared pin selected", uart_rxd, 0);
    ticks(16);
    check(uart_rxd, "R9 shared rx released", uart_rxd, 1);

    // carrier rx: R10
    mode_ask = 1'b1; route_ir = 1'b1;
    for (int i = 0; i < 10; i++) begin
      irrx = ~irrx;
      repeat (HALF) @(negedge clk);
    end
    check(!uart_rxd, "R10 low during carrier", uart_rxd, 0);
    irrx = 1'b0;
    repeat (2 * HALF) @(negedge clk);
    check(!uart_rxd, "R10 low inside window", uart_rxd, 0);
    repeat (4 * HALF) @(negedge clk);
    check(uart_rxd, "R10 high after silence", uart_rxd, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule